// File: doc/BRIEF.md
# Multi-Channel Double-Buffered PWM Bank

This block drives a set of independent pulse-width outputs from one shared tick enable (nominally 1 MHz) through a small word-addressed register interface. Each channel has a period, a duty and a control word. The control word selects a prescale ratio and the output polarity. Software stages changes in shadow copies. A write to a channel's period word bundles the current shadows into a pending set. The running channel adopts that set only when its current period ends, so the waveform never carries a mix of old and new settings.

A period of zero stops the channel. The stop, like any other update, waits for the running period to finish. The output then rests low whatever the polarity. A stopped channel starts a newly committed non-zero setting on the next raw tick, without waiting. Reads return the shadow words. A status word shows, per channel, whether a commit is still pending and whether the channel is running.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, the status word reads 0 and all shadow words read 0.
- R2: For channel c the period word is at 0x400+4c, the duty word at 0x420+4c and the control word at 0x440+4c. Each reads back the last value written. The control word reads back only bits [1:0] and bit 5, so writing 0xFFFFFFFF reads back 0x23.
- R3: Writing duty or control without a following period write leaves the output unchanged.
- R4: A period write commits the staged duty and control values. The old settings keep running until the current period ends, and the new set then takes effect on that same tick.
- R5: Control bits [1:0] pick 1, 2, 4 or 8 raw ticks per count for the codes 00, 01, 10 and 11. After a load, the first count advance happens on the Nth raw tick.
- R6: Control bit 5 = 0 makes the active level high. Bit 5 = 1 makes it low.
- R7: The output is active while the count (0 to period-1) is below duty. Duty 0 gives a constant inactive level, and duty ≥ period gives a constant active level.
- R8: Committing period 0 finishes the running period. The output then stays low regardless of polarity, and the running bit clears.
- R9: While stopped, writes to duty or control produce no pulses.
- R10: A non-zero commit to a stopped channel loads on the next raw tick.
- R11: The status word at 0x460 has bit c set while channel c has a commit pending, and bit 16+c set while channel c runs.
- R12: Channels do not interact: configuring one channel leaves the others' outputs unchanged.
- R13: A new commit made while a stop is still pending replaces the stop. The channel then moves straight from the old period into the new settings and never passes through a stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Raw time-base enable, one cycle per tick |
| wr_i | input | 1 | Write strobe, single cycle |
| rd_i | input | 1 | Read strobe; read data is combinational |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when rd_i is low |
| pwm_o | output | 8 | Per-channel PWM outputs |

## Verification
The hardest situation to reach from the ports is a second commit that lands while a stop is still waiting for the period boundary. The bench starts a long, always-high period, then issues a stop, a duty rewrite and a fresh non-zero period in consecutive cycles, all well inside that period. While the pending bit is set, it polls the status word every cycle and flags any cycle in which the running bit drops before the new setting appears. Prescale ratios are told apart by counting raw ticks from the load until the first falling edge, because a duty-over-window ratio cannot distinguish them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PER_BASE  = 'h400;
  localparam int unsigned DUTY_BASE = 'h420;
  localparam int unsigned CTL_BASE  = 'h440;
  localparam int unsigned STAT_ADDR = 'h460;
  localparam int unsigned RUN_LSB   = 16;
  localparam int unsigned POL_BIT   = 5;

  typedef struct packed {
    logic       pol;
    logic [1:0] div;
  } ctl_t;
endpackage

// File: rtl/pwm_decode.sv
module pwm_decode
  import pwm_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned AW   = 12
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic [N_CH-1:0] per_we_o,
  output logic [N_CH-1:0] duty_we_o,
  output logic [N_CH-1:0] ctl_we_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign per_we_o[c]  = wr_i && (addr_i == AW'(PER_BASE  + 4 * c));
    assign duty_we_o[c] = wr_i && (addr_i == AW'(DUTY_BASE + 4 * c));
    assign ctl_we_o[c]  = wr_i && (addr_i == AW'(CTL_BASE  + 4 * c));
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ptick_o
);
  localparam int unsigned PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] pre_q;
  logic [PS_W-1:0] lim;

  assign lim     = PS_W'((1 << div_i) - 1);
  assign ptick_o = tick_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (clr_i)     pre_q <= '0;
    else if (ptick_o)   pre_q <= '0;
    else if (tick_i)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          commit_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] duty_i,
  input  ctl_t          ctl_i,
  output logic          pwm_o,
  output logic          run_o,
  output logic          pend_o,
  output logic          load_o
);
  logic [CW-1:0] stg_per, stg_duty, act_per, act_duty, cnt_q;
  ctl_t          stg_ctl, act_ctl;
  logic          pend_q, run, ptick, end_per, load;

  assign run     = (act_per != '0);
  assign end_per = ptick && (cnt_q == CW'(act_per - 1'b1));
  // stopped channel loads on the raw tick, running one at its boundary
  assign load    = pend_q && (run ? end_per : tick_i);

  pwm_prescale #(.DIV_W(2)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (load || !run),
    .div_i   (act_ctl.div),
    .ptick_o (ptick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_per  <= '0;
      stg_duty <= '0;
      stg_ctl  <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (commit_i) begin
        stg_per  <= per_i;
        stg_duty <= duty_i;
        stg_ctl  <= ctl_i;
        pend_q   <= 1'b1;
      end else if (load) begin
        pend_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per  <= '0;
      act_duty <= '0;
      act_ctl  <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      act_per  <= stg_per;
      act_duty <= stg_duty;
      act_ctl  <= stg_ctl;
      cnt_q    <= '0;
    end else if (!run) begin
      cnt_q    <= '0;
    end else if (ptick) begin
      cnt_q    <= end_per ? '0 : cnt_q + 1'b1;
    end
  end

  assign pwm_o  = run && ((cnt_q < act_duty) ^ act_ctl.pol);
  assign run_o  = run;
  assign pend_o = pend_q;
  assign load_o = load;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CW   = 16,
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] pwm_o
);
  logic [N_CH-1:0] per_we, duty_we, ctl_we;
  logic [N_CH-1:0] run_w, pend_w, load_w;
  logic [CW-1:0]   sh_per  [N_CH];
  logic [CW-1:0]   sh_duty [N_CH];
  ctl_t            sh_ctl  [N_CH];
  logic [DW-1:0]   stat;

  pwm_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .per_we_o  (per_we),
    .duty_we_o (duty_we),
    .ctl_we_o  (ctl_we)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_per[c]  <= '0;
        sh_duty[c] <= '0;
        sh_ctl[c]  <= '0;
      end else begin
        if (per_we[c])  sh_per[c]  <= wdata_i[CW-1:0];
        if (duty_we[c]) sh_duty[c] <= wdata_i[CW-1:0];
        if (ctl_we[c])  sh_ctl[c]  <= '{pol: wdata_i[POL_BIT], div: wdata_i[1:0]};
      end
    end

    pwm_channel #(.CW(CW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .commit_i (per_we[c]),
      .per_i    (wdata_i[CW-1:0]),
      .duty_i   (sh_duty[c]),
      .ctl_i    (sh_ctl[c]),
      .pwm_o    (pwm_o[c]),
      .run_o    (run_w[c]),
      .pend_o   (pend_w[c]),
      .load_o   (load_w[c])
    );
  end

  always_comb begin
    stat = '0;
    for (int c = 0; c < N_CH; c++) begin
      stat[c]           = pend_w[c];
      stat[RUN_LSB + c] = run_w[c];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr_i == AW'(PER_BASE + 4 * c))  rdata_o = DW'(sh_per[c]);
        if (addr_i == AW'(DUTY_BASE + 4 * c)) rdata_o = DW'(sh_duty[c]);
        if (addr_i == AW'(CTL_BASE + 4 * c))
          rdata_o = DW'({sh_ctl[c].pol, 3'b000, sh_ctl[c].div});
      end
      if (addr_i == AW'(STAT_ADDR)) rdata_o = stat;
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            wr_i,
  input logic [N_CH-1:0] pwm_o,
  input logic [N_CH-1:0] run_i,
  input logic [N_CH-1:0] pend_i,
  input logic [N_CH-1:0] load_i
);
  for (genvar c = 0; c < N_CH; c++) begin : g_a
    p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(pwm_o[c]));

    p_run_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(run_i[c]));

    p_pend_set_by_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[c]) |-> $past(wr_i));

    p_pend_clear_at_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[c] && !wr_i |=> !pend_i[c]);

    p_stop_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_i[c]) |-> !pwm_o[c]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .pwm_o  (pwm_o),
  .run_i  (run_w),
  .pend_i (pend_w),
  .load_i (load_w)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int N_CH       = 8;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic [7:0]  ctl;
    logic [7:0]  win;
    logic [7:0]  hi;
  } vec_t;

  // period, duty, control, window in raw ticks, expected high samples
  localparam vec_t VEC [8] = '{
    '{16'd4, 16'd1, 8'h00, 8'd4,  8'd1},   // R7
    '{16'd4, 16'd3, 8'h01, 8'd8,  8'd6},   // R5
    '{16'd5, 16'd2, 8'h02, 8'd20, 8'd8},   // R5
    '{16'd3, 16'd1, 8'h03, 8'd24, 8'd8},   // R5
    '{16'd4, 16'd1, 8'h20, 8'd4,  8'd3},   // R6
    '{16'd4, 16'd0, 8'h00, 8'd4,  8'd0},   // R7
    '{16'd4, 16'd9, 8'h00, 8'd4,  8'd4},   // R7
    '{16'd6, 16'd6, 8'h20, 8'd6,  8'd0}    // R6
  };

  logic        clk, rst_n, tick, wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [N_CH-1:0] pwm;
  int nchk = 0, nerr = 0;

  pwm_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int t;
    t = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = rst_n && (t == TICK_DIV - 1);
      t = (t + 1) % TICK_DIV;
    end
  end

  function automatic logic [11:0] a_per(int c);  return 12'(32'h400 + 4 * c); endfunction
  function automatic logic [11:0] a_duty(int c); return 12'(32'h420 + 4 * c); endfunction
  function automatic logic [11:0] a_ctl(int c);  return 12'(32'h440 + 4 * c); endfunction
  localparam logic [11:0] A_STAT = 12'h460;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  // poll until pending clears; report whether the run bit ever dropped
  task automatic poll_clear(int c, output logic stopped);
    logic [31:0] s;
    stopped = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(A_STAT, s);
      if (!s[16 + c]) stopped = 1'b1;
      if (!s[c]) break;
    end
  endtask

  task automatic count_hi(int c, int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      if (pwm[c]) hi++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic stp;
    int hi;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'(pwm), 0);
    rst_n = 1'b1;
    rd_reg(A_STAT, d);    chk("R1 status", d, 0);
    rd_reg(a_per(0), d);  chk("R1 period shadow", d, 0);
    chk("R1 outputs", 32'(pwm), 0);

    // table walk on channel 0
    for (int i = 0; i < 8; i++) begin
      wr_reg(a_duty(0), 32'(VEC[i].duty));
      wr_reg(a_ctl(0),  32'(VEC[i].ctl));
      wr_reg(a_per(0),  32'(VEC[i].per));
      poll_clear(0, stp);
      count_hi(0, int'(VEC[i].win), hi);
      chk($sformatf("R7 R6 vector %0d high count", i), 32'(hi), 32'(VEC[i].hi));
    end

    // R5: raw ticks from load to first count advance
    for (int dv = 0; dv < 4; dv++) begin
      int n;
      wr_reg(a_duty(0), 1);
      wr_reg(a_ctl(0), 32'(dv));
      wr_reg(a_per(0), 4);
      poll_clear(0, stp);
      n = 0;
      for (int k = 0; k < 20; k++) begin
        wait_tick();
        if (!pwm[0]) break;
        n++;
      end
      chk($sformatf("R5 prescale code %0d", dv), 32'(n), 32'((1 << dv) - 1));
    end

    // R2 readback on channel 4
    wr_reg(a_per(4), 32'h1234);
    wr_reg(a_duty(4), 32'h55);
    wr_reg(a_ctl(4), 32'hFFFF_FFFF);
    rd_reg(a_per(4), d);  chk("R2 period readback", d, 32'h1234);
    rd_reg(a_duty(4), d); chk("R2 duty readback", d, 32'h55);
    rd_reg(a_ctl(4), d);  chk("R2 control readback", d, 32'h23);

    // R3 / R4 on channel 1
    wr_reg(a_duty(1), 8);
    wr_reg(a_ctl(1), 0);
    wr_reg(a_per(1), 8);
    poll_clear(1, stp);
    chk("R4 running high", 32'(pwm[1]), 1);
    wr_reg(a_duty(1), 0);
    count_hi(1, 20, hi);
    chk("R3 duty shadow ignored", 32'(hi), 20);
    wr_reg(a_per(1), 8);
    rd_reg(A_STAT, d);
    chk("R11 pending after commit", 32'(d[1]), 1);
    chk("R4 old setting until boundary", 32'(pwm[1]), 1);
    poll_clear(1, stp);
    chk("R4 new setting after boundary", 32'(pwm[1]), 0);
    rd_reg(A_STAT, d);
    chk("R11 running bit", 32'(d[17]), 1);

    // R8 stop with low active level
    wr_reg(a_ctl(1), 32'h20);
    wr_reg(a_per(1), 8);
    poll_clear(1, stp);
    chk("R6 inactive high when bit5 set", 32'(pwm[1]), 1);
    wr_reg(a_per(1), 0);
    chk("R8 period finishes before stop", 32'(pwm[1]), 1);
    poll_clear(1, stp);
    chk("R8 low after stop", 32'(pwm[1]), 0);
    rd_reg(A_STAT, d);
    chk("R8 running bit cleared", 32'(d[17]), 0);
    count_hi(1, 16, hi);
    chk("R8 stays low", 32'(hi), 0);

    // R9 writes while stopped
    wr_reg(a_duty(1), 5);
    wr_reg(a_ctl(1), 0);
    count_hi(1, 16, hi);
    chk("R9 no pulses while stopped", 32'(hi), 0);
    rd_reg(A_STAT, d);
    chk("R9 still stopped", 32'(d[17]), 0);

    // R10 restart from stopped
    wr_reg(a_duty(1), 4);
    wr_reg(a_per(1), 4);
    wait_tick();
    chk("R10 output on first tick", 32'(pwm[1]), 1);
    rd_reg(A_STAT, d);
    chk("R10 loaded on first tick", 32'({d[17], d[1]}), 32'b10);

    // R13 stop overridden by a new commit
    wr_reg(a_duty(2), 8);
    wr_reg(a_ctl(2), 0);
    wr_reg(a_per(2), 8);
    poll_clear(2, stp);
    wait_tick();
    wr_reg(a_per(2), 0);
    wr_reg(a_duty(2), 0);
    wr_reg(a_per(2), 4);
    chk("R13 old period continues", 32'(pwm[2]), 1);
    poll_clear(2, stp);
    chk("R13 never stopped", 32'(stp), 0);
    chk("R13 new setting active", 32'(pwm[2]), 0);

    // R12 independence
    count_hi(1, 8, hi);
    chk("R12 channel 1 unaffected", 32'(hi), 8);
    wr_reg(a_duty(7), 1);
    wr_reg(a_per(7), 2);
    poll_clear(7, stp);
    count_hi(7, 2, hi);
    chk("R12 channel 7 own waveform", 32'(hi), 1);
    chk("R12 unused channels idle", 32'(pwm[6:3]), 0);
    count_hi(1, 8, hi);
    chk("R12 channel 1 after channel 7", 32'(hi), 8);

    summary();
    $finish;
  end
endmodule